// File: doc/BRIEF.md
# Display Channel Mode Controller

This block decides which of three operating modes a dual-mode serial configuration memory is in. After reset it is in the streaming (transmit-only) mode, where contents are clocked out by the video-rate clock. A falling edge on the bus clock moves it into a tentative transition mode. There it counts video-clock pulses while it waits for the bus slave to report a control byte that matches the device code 1010000.

When the slave reports a match, the controller locks into bidirectional mode, and only a reset can bring it out again. If 128 video-clock pulses arrive while the bus clock stays idle, it falls back to streaming mode. At that moment it sends a one-cycle restart pulse that tells the streamer to start again from the most significant bit of address 00h. In bidirectional mode the video clock is no longer counted. Its level is passed through as the write-enable for the slave.

The block has three states. `MODE_TXONLY` (code 2'b00) is the streaming mode. `MODE_TRANS` (2'b01) is the tentative mode. `MODE_BIDIR` (2'b10) is the locked bus mode. It has four transitions. TXONLY goes to TRANS on a bus-clock fall. TRANS goes to BIDIR on an address match. TRANS goes back to TXONLY on a pulse timeout. Reset returns any state to TXONLY. All inputs are single-cycle strobes or levels that are already synchronised to `clk`.

Top module: `ddc_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it rises, `mode` is 2'b00 (streaming), `restart` is 0 and `wr_en` is 0, including when the controller was in bidirectional mode before the reset.
- R2: In streaming mode, a `scl_fall` strobe makes `mode` read 2'b01 (transition) after the next rising clock edge.
- R3: In transition mode, each `vclk_rise` strobe adds one to a pulse count that starts at zero on entry. A `scl_fall` strobe clears the count to zero, and it wins over a `vclk_rise` in the same cycle, so that pulse is not counted.
- R4: Once the count has reached 128, the next clock edge returns `mode` to 2'b00. The count then stays at 128 and does not go higher. A count of 127 or less never causes this fall-back.
- R5: `restart` is high for exactly one clock cycle, in the same cycle that `mode` first reads 2'b00 after a timeout. It never rises on any other occasion.
- R6: In transition mode, an `addr_hit` strobe makes `mode` read 2'b10 (bidirectional) after the next clock edge. A match wins over a timeout that is pending in the same cycle and over a `scl_fall` in the same cycle.
- R7: In bidirectional mode, `mode` stays at 2'b10 whatever `scl_fall`, `vclk_rise` and `addr_hit` do, until reset.
- R8: `wr_en` equals `vclk_level` while `mode` is 2'b10, and is 0 in every other mode.
- R9: In streaming mode, `addr_hit` and `vclk_rise` strobes leave `mode` at 2'b00 and never raise `restart`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-on) |
| scl_fall | input | 1 | One-cycle strobe: the bus clock fell |
| vclk_rise | input | 1 | One-cycle strobe: the video clock rose |
| vclk_level | input | 1 | Synchronised level of the video clock |
| addr_hit | input | 1 | One-cycle strobe from the bus slave: the control byte matched |
| mode | output | 2 | Current mode: 00 streaming, 01 transition, 10 bidirectional |
| restart | output | 1 | One-cycle pulse: the streamer restarts at address 00h, MSB |
| wr_en | output | 1 | Write-enable for the bus slave |

## Verification
On every cycle the assertions check several properties that hold in any state. The bidirectional lock never releases. The pulse count never passes 128, and it is zero one cycle after a clear. `restart` lasts a single cycle and follows a transition-mode cycle. A bus-clock fall in streaming mode always leads to transition mode. `wr_en` appears only in bidirectional mode. Only the bench's scenarios can show the exact pulse counts, because they depend on the history of strobes. The bench sweeps the pulse count around the 128 boundary and counts how many restarts each run produces. It also clears the count partway through a run, and it tests which input wins when strobes coincide.

// File: rtl/ddc_mode_pkg.sv
package ddc_mode_pkg;
    typedef enum logic [1:0] {
        MODE_TXONLY = 2'b00,
        MODE_TRANS  = 2'b01,
        MODE_BIDIR  = 2'b10
    } mode_e;
endpackage

// File: rtl/ddc_pulse_counter.sv
module ddc_pulse_counter #(
    parameter int LIMIT = 128,
    parameter int CW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] count,
    output logic          reached
);
    localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              count <= '0;
        else if (clr)            count <= '0;
        else if (inc && count != LIM_V) count <= count + 1'b1;
    end

    assign reached = (count == LIM_V);

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LIM_V); // R4
    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0); // R3
endmodule

// File: rtl/ddc_mode_fsm.sv
module ddc_mode_fsm
    import ddc_mode_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  scl_fall,
    input  logic  addr_hit,
    input  logic  timeout,
    input  logic  vclk_level,
    output mode_e state,
    output logic  cnt_clr,
    output logic  restart,
    output logic  wr_en
);
    mode_e state_d;

    always_comb begin
        state_d = state;
        unique case (state)
            MODE_TXONLY: if (scl_fall) state_d = MODE_TRANS;
            MODE_TRANS: begin
                if (addr_hit)                 state_d = MODE_BIDIR;
                else if (timeout && !scl_fall) state_d = MODE_TXONLY;
            end
            MODE_BIDIR:  state_d = MODE_BIDIR;
            default:     state_d = MODE_TXONLY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= MODE_TXONLY;
        else        state <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) restart <= 1'b0;
        else        restart <= (state == MODE_TRANS) && (state_d == MODE_TXONLY);
    end

    assign cnt_clr = scl_fall || (state != MODE_TRANS);
    assign wr_en   = (state == MODE_BIDIR) && vclk_level;

    AST_BIDIR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        state == MODE_BIDIR |=> state == MODE_BIDIR); // R7
    AST_RESTART_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !restart); // R5
    AST_RESTART_AFTER_TRANS: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> (state == MODE_TXONLY && $past(state) == MODE_TRANS)); // R5
    AST_FALL_ENTERS_TRANS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MODE_TXONLY && scl_fall) |=> state == MODE_TRANS); // R2
    AST_HIT_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MODE_TRANS && addr_hit) |=> state == MODE_BIDIR); // R6
    AST_WE_ONLY_BIDIR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> state == MODE_BIDIR); // R8
endmodule

// File: rtl/ddc_mode_ctrl.sv
module ddc_mode_ctrl
    import ddc_mode_pkg::*;
#(
    parameter int IDLE_PULSES = 128,
    parameter int CNT_W       = $clog2(IDLE_PULSES + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_fall,
    input  logic       vclk_rise,
    input  logic       vclk_level,
    input  logic       addr_hit,
    output logic [1:0] mode,
    output logic       restart,
    output logic       wr_en
);
    mode_e            state;
    logic             cnt_clr;
    logic             timeout;
    logic [CNT_W-1:0] pulse_cnt;

    ddc_pulse_counter #(.LIMIT(IDLE_PULSES), .CW(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cnt_clr),
        .inc     (vclk_rise),
        .count   (pulse_cnt),
        .reached (timeout)
    );

    ddc_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_fall   (scl_fall),
        .addr_hit   (addr_hit),
        .timeout    (timeout),
        .vclk_level (vclk_level),
        .state      (state),
        .cnt_clr    (cnt_clr),
        .restart    (restart),
        .wr_en      (wr_en)
    );

    assign mode = state;

    AST_COUNT_IDLE_OUTSIDE_TRANS: assert property (@(posedge clk) disable iff (!rst_n)
        (state != MODE_TRANS) |=> (state != MODE_TRANS || pulse_cnt == '0)); // R3
endmodule

// File: tb/ddc_mode_ctrl_bench.sv
module ddc_mode_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_fall = 1'b0, vclk_rise = 1'b0, vclk_level = 1'b0, addr_hit = 1'b0;
    logic [1:0] mode;
    logic restart, wr_en;
    int errors = 0, checks = 0, rcnt = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ddc_mode_ctrl u_ddc_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .vclk_rise(vclk_rise),
        .vclk_level(vclk_level), .addr_hit(addr_hit),
        .mode(mode), .restart(restart), .wr_en(wr_en)
    );

    always @(negedge clk) if (rst_n && restart) rcnt++;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic do_reset;
        rst_n = 1'b0; scl_fall = 0; vclk_rise = 0; addr_hit = 0;
        tick(2);
        rst_n = 1'b1;
        rcnt = 0;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            vclk_rise = 1'b1; tick(1); vclk_rise = 1'b0;
        end
    endtask

    task automatic sfall;
        scl_fall = 1'b1; tick(1); scl_fall = 1'b0;
    endtask

    task automatic hit;
        addr_hit = 1'b1; tick(1); addr_hit = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        vclk_level = 1'b1;
        rst_n = 1'b0; tick(2);
        chk("R1 mode in reset", mode, 0);
        chk("R1 restart in reset", restart, 0);
        chk("R1 wr_en in reset", wr_en, 0);
        rst_n = 1'b1; tick(1);
        chk("R1 mode after reset", mode, 0);

        // R9: streaming ignores pulses and matches
        pulses(200); hit(); tick(2);
        chk("R9 mode stays streaming", mode, 0);
        chk("R9 no restart", rcnt, 0);

        // R2
        sfall();
        chk("R2 enter transition", mode, 1);
        chk("R8 wr_en low in transition", wr_en, 0);

        // R4/R5 sweep around the boundary
        for (int n = 0; n <= 132; n++) begin
            if (n > 4 && n < 120 && n != 64) continue;
            do_reset(); sfall(); pulses(n); tick(2);
            chk($sformatf("R4 mode after %0d pulses", n), mode, (n >= 128) ? 0 : 1);
            chk($sformatf("R5 restarts after %0d pulses", n), rcnt, (n >= 128) ? 1 : 0);
        end

        // R4/R5 exact timing
        do_reset(); sfall(); pulses(128);
        chk("R4 still transition at count 128", mode, 1);
        tick(1);
        chk("R4 streaming one edge later", mode, 0);
        chk("R5 restart high", restart, 1);
        tick(1);
        chk("R5 restart one cycle", restart, 0);

        // R3 clear midway
        do_reset(); sfall(); pulses(100); sfall(); pulses(100); tick(2);
        chk("R3 cleared count keeps transition", mode, 1);
        pulses(27); tick(2);
        chk("R3 127 after clear", mode, 1);
        pulses(1); tick(1);
        chk("R3 128 after clear", mode, 0);

        // R3 clear wins over simultaneous pulse
        do_reset(); sfall(); pulses(127);
        scl_fall = 1; vclk_rise = 1; tick(1); scl_fall = 0; vclk_rise = 0;
        pulses(127); tick(2);
        chk("R3 coincident pulse not counted", mode, 1);
        pulses(1); tick(1);
        chk("R3 timeout after fresh 128", mode, 0);

        // R6 match
        do_reset(); sfall(); pulses(50); hit();
        chk("R6 enter bidirectional", mode, 2);
        // R6 match beats pending timeout
        do_reset(); sfall(); pulses(128); hit(); tick(2);
        chk("R6 match over timeout", mode, 2);
        chk("R6 no restart", rcnt, 0);
        // R6 match beats scl_fall
        do_reset(); sfall(); scl_fall = 1; addr_hit = 1; tick(1); scl_fall = 0; addr_hit = 0;
        chk("R6 match over scl_fall", mode, 2);

        // R7 lock
        pulses(300); sfall(); hit(); sfall(); pulses(130); tick(3);
        chk("R7 locked", mode, 2);
        chk("R7 no restart", rcnt, 0);

        // R8
        vclk_level = 1'b1; #1;
        chk("R8 wr_en follows high", wr_en, 1);
        vclk_level = 1'b0; #1;
        chk("R8 wr_en follows low", wr_en, 0);
        vclk_level = 1'b1;

        // R1 reset from bidirectional
        do_reset(); tick(1);
        chk("R1 reset leaves bidirectional", mode, 0);
        chk("R1 wr_en after reset", wr_en, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule